// File: doc/BRIEF.md
# RNG Bit-Select Sample Assembler

This block stands between a 4-bit raw noise source and the health-test logic and turns the incoming noise words into test symbols. It has two modes. In pass-through mode every accepted noise word becomes one symbol. In bit-select mode the block takes one chosen bit position from each of four accepted noise words and packs those four bits into one symbol. The first accepted word supplies bit 0 of the symbol.

The block also drives the enable line of the noise source. When software turns the block on, the mode and bit index are captured and the source enable rises. When software turns the block off, any half-built bit-select symbol is thrown away. The source enable stays high for a fixed two-cycle tail, and words that arrive during that tail are taken in and dropped. Software can raise its enable again during the tail, but the block restarts only after the tail has ended.

Top module: `rng_bitsel_assembler`

## Requirements
- R1: After reset, `symValid` and `noiseEnable` are both 0.
- R2: When `swEnable` is sampled high while the block is stopped, `noiseEnable` is 1 after that clock edge.
- R3: In pass-through mode (`bitSelMode` = 0 at enable), each noise word accepted while running appears unchanged on `symData` with `symValid` = 1 in the cycle after the edge that accepts it.
- R4: In bit-select mode (`bitSelMode` = 1 at enable), four accepted words form one symbol. Bit i of `symData` equals bit `bitIndex` of the i-th word, with i counting from 0. The symbol appears in the cycle after the fourth word is accepted.
- R5: `symValid` is high for exactly one cycle per completed symbol, and it is 0 in every cycle whose previous edge completed no symbol.
- R6: If `swEnable` is sampled low at edge t while the block is running, `noiseEnable` stays 1 after edges t and t+1 and is 0 after edge t+2.
- R7: No symbol is produced from a word presented at the disabling edge t, from words presented during the tail, or from a partial symbol that is pending at the disable.
- R8: After a disable and a new enable, the next bit-select symbol is built only from words accepted after the new enable.
- R9: `bitSelMode` and `bitIndex` are captured when the block starts. Changes to them while the block is running have no effect on the symbols produced.
- R10: Noise words presented while the block is stopped produce no symbol and do not count toward a later bit-select symbol.
- R11: If `swEnable` is raised again during the tail, `noiseEnable` still falls after edge t+2. It then rises after edge t+3, and the mode and index are captured again at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swEnable | input | 1 | Software run request (level) |
| bitSelMode | input | 1 | 1 = bit-select packing, 0 = pass-through; captured at start |
| bitIndex | input | 2 | Bit position taken from each word in bit-select mode; captured at start |
| noiseEnable | output | 1 | Enable to the noise source |
| noiseValid | input | 1 | Noise word valid |
| noiseData | input | 4 | Noise word |
| symValid | output | 1 | One-cycle strobe for a completed symbol |
| symData | output | 4 | Completed symbol |

## Verification
The completing fourth word of a bit-select symbol and the software disable can be sampled at the same clock edge. In that case the emit and the flush compete. The bench provokes this by driving `swEnable` low in the same cycle that it presents the fourth word. The result is judged at the ports: the scoreboard queue holds no expectation for that word, so any `symValid` in the following cycles is reported as an unexpected symbol. A later enable then has to build a clean symbol from four fresh words. A second overlap is a re-enable that arrives during the tail. For that case the bench checks the exact cycle in which `noiseEnable` falls and the cycle in which it rises again.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } runState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latchCfg;  // capture mode and index, clear assembly
    logic take;      // accept the current noise word
    logic flush;     // drop any partial symbol
  } asmStrobe_t;

endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int TAIL_CYCLES = 2   // must be at least 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swEnable,
  input  logic       noiseValid,
  output asmStrobe_t stb,
  output logic       noiseEnable
);

  localparam int CNT_W = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYCLES - 1);

  runState_t       state;
  logic [CNT_W-1:0] tailCnt;

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: stb.latchCfg = swEnable;
      ST_RUN: begin
        if (!swEnable) stb.flush = 1'b1;
        else           stb.take  = noiseValid;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tailCnt     <= '0;
      noiseEnable <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (swEnable) begin
            state       <= ST_RUN;
            noiseEnable <= 1'b1;
          end
        end
        ST_RUN: begin
          if (!swEnable) begin
            state   <= ST_TAIL;
            tailCnt <= TAIL_LOAD;
          end
        end
        ST_TAIL: begin
          if (tailCnt == '0) begin
            state       <= ST_IDLE;
            noiseEnable <= 1'b0;
          end else begin
            tailCnt <= tailCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a start request in idle raises the source enable
  a_r2_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && swEnable) |=> noiseEnable);

  // R6: enable held through the tail
  a_r6_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && tailCnt != '0) |=> noiseEnable);

  // R6: enable drops when the tail expires
  a_r6_tail_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && tailCnt == '0) |=> !noiseEnable);

  // R7: words are only taken while the source is enabled and running
  a_r7_take_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    stb.take |-> (noiseEnable && !stb.flush));

endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int BUS_W = 4,
  localparam int SEL_W = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  asmStrobe_t       stb,
  input  logic             cfgBitSel,
  input  logic [SEL_W-1:0] cfgIdx,
  input  logic [BUS_W-1:0] noiseData,
  output logic             symValid,
  output logic [BUS_W-1:0] symData
);

  localparam int FILL_W = SEL_W;
  localparam logic [FILL_W-1:0] LAST_SLOT = FILL_W'(BUS_W - 1);

  logic             modeQ;
  logic [SEL_W-1:0] idxQ;
  logic [FILL_W-1:0] fillCnt;
  logic [BUS_W-1:0] partial;
  logic [BUS_W-1:0] nextPartial;
  logic             selBit;

  assign selBit = noiseData[idxQ];

  // Insert the selected bit into the slot given by the fill count
  for (genvar i = 0; i < BUS_W; i++) begin : g_slot
    assign nextPartial[i] = (fillCnt == FILL_W'(i)) ? selBit : partial[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ    <= 1'b0;
      idxQ     <= '0;
      fillCnt  <= '0;
      partial  <= '0;
      symValid <= 1'b0;
      symData  <= '0;
    end else begin
      symValid <= 1'b0;
      if (stb.latchCfg) begin
        modeQ   <= cfgBitSel;
        idxQ    <= cfgIdx;
        fillCnt <= '0;
        partial <= '0;
      end else if (stb.flush) begin
        fillCnt <= '0;
        partial <= '0;
      end else if (stb.take) begin
        if (!modeQ) begin
          symData  <= noiseData;
          symValid <= 1'b1;
        end else if (fillCnt == LAST_SLOT) begin
          symData  <= nextPartial;
          symValid <= 1'b1;
          fillCnt  <= '0;
          partial  <= '0;
        end else begin
          partial <= nextPartial;
          fillCnt <= fillCnt + 1'b1;
        end
      end
    end
  end

  // R5: every symbol strobe is caused by an accepted word one cycle earlier
  a_r5_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    symValid |-> $past(stb.take));

  // R8: a flush leaves no partial symbol behind
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flush |=> (fillCnt == '0 && !symValid));

  // R9: captured configuration only changes at a start
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.latchCfg |=> ($stable(modeQ) && $stable(idxQ)));

  // R4: pass-through mode never accumulates
  a_r4_no_fill_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !modeQ |-> fillCnt == '0);

endmodule

// File: rtl/rng_bitsel_assembler.sv
module rng_bitsel_assembler
  import rbs_pkg::*;
#(
  parameter int BUS_W       = 4,
  parameter int TAIL_CYCLES = 2,
  localparam int SEL_W      = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swEnable,
  input  logic             bitSelMode,
  input  logic [SEL_W-1:0] bitIndex,
  output logic             noiseEnable,
  input  logic             noiseValid,
  input  logic [BUS_W-1:0] noiseData,
  output logic             symValid,
  output logic [BUS_W-1:0] symData
);

  asmStrobe_t stb;

  rbs_ctrl #(.TAIL_CYCLES(TAIL_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .swEnable   (swEnable),
    .noiseValid (noiseValid),
    .stb        (stb),
    .noiseEnable(noiseEnable)
  );

  rbs_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .cfgBitSel(bitSelMode),
    .cfgIdx   (bitIndex),
    .noiseData(noiseData),
    .symValid (symValid),
    .symData  (symData)
  );

endmodule

// File: tb/rng_bitsel_assembler_bench.sv
module rng_bitsel_assembler_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swEnable = 1'b0;
  logic       bitSelMode = 1'b0;
  logic [1:0] bitIndex = '0;
  logic       noiseEnable;
  logic       noiseValid = 1'b0;
  logic [3:0] noiseData = '0;
  logic       symValid;
  logic [3:0] symData;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0] expQ[$];
  string      tagQ[$];

  // bench model state
  bit         mRunning = 0;
  bit         mMode = 0;
  int         mIdx = 0;
  int         mFill = 0;
  logic [3:0] mPart = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_bitsel_assembler u_rng_bitsel_assembler (
    .clk(clk), .rst_n(rst_n), .swEnable(swEnable), .bitSelMode(bitSelMode),
    .bitIndex(bitIndex), .noiseEnable(noiseEnable), .noiseValid(noiseValid),
    .noiseData(noiseData), .symValid(symValid), .symData(symData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && symValid && !finished) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7", "unexpected symbol", symData, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(symData == e, t, "symbol value", symData, e);
      end
    end
  end

  task automatic push(input logic [3:0] v, input string t);
    expQ.push_back(v);
    tagQ.push_back(t);
  endtask

  // present one word for one cycle, starting and ending at a falling edge
  task automatic sample(input logic [3:0] d);
    noiseValid = 1'b1;
    noiseData  = d;
    if (mRunning && swEnable) begin
      if (!mMode) push(d, "R3");
      else begin
        mPart[mFill] = d[mIdx];
        if (mFill == 3) begin
          push(mPart, "R4");
          mFill = 0;
          mPart = '0;
        end else mFill++;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    noiseValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input bit mode, input logic [1:0] idx);
    bitSelMode = mode;
    bitIndex   = idx;
    swEnable   = 1'b1;
    noiseValid = 1'b0;
    @(negedge clk);
    chk(noiseEnable == 1'b1, "R2", "enable after start", noiseEnable, 1);
    mMode = mode; mIdx = idx; mFill = 0; mPart = '0; mRunning = 1;
  endtask

  // disable with optional words in the disable cycle and tail, optional re-raise
  task automatic stop(input bit withWords, input bit reRaise);
    swEnable   = 1'b0;
    noiseValid = withWords;
    noiseData  = 4'hF;
    mRunning = 0; mFill = 0; mPart = '0;
    @(negedge clk);
    chk(noiseEnable == 1'b1, "R6", "enable after t", noiseEnable, 1);
    if (reRaise) swEnable = 1'b1;
    noiseData = 4'h5;
    @(negedge clk);
    chk(noiseEnable == 1'b1, "R6", "enable after t+1", noiseEnable, 1);
    noiseValid = 1'b0;
    @(negedge clk);
    chk(noiseEnable == 1'b0, reRaise ? "R11" : "R6", "enable after t+2", noiseEnable, 0);
    if (reRaise) begin
      @(negedge clk);
      chk(noiseEnable == 1'b1, "R11", "enable after t+3", noiseEnable, 1);
      mMode = bitSelMode; mIdx = bitIndex; mFill = 0; mPart = '0; mRunning = 1;
    end
    idle(2);
    chk(expQ.size() == 0, "R7", "pending expectations", expQ.size(), 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
          checks++; bad++;
          $display("FAIL watchdog expired: actual=1 expected=0");
          finished = 1;
          $display("  test done: total=%0d bad=%0d", checks, bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    chk(symValid == 1'b0, "R1", "symValid in reset", symValid, 0);
    chk(noiseEnable == 1'b0, "R1", "noiseEnable in reset", noiseEnable, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(symValid == 1'b0 && noiseEnable == 1'b0, "R1", "after reset release",
        {symValid, noiseEnable}, 0);

    // R10: words while stopped are ignored
    sample(4'h1); sample(4'h1); sample(4'h1);
    idle(1);
    chk(noiseEnable == 1'b0, "R10", "source stays off", noiseEnable, 0);

    // R3: pass-through, back to back then gaps
    start(1'b0, 2'd0);
    sample(4'hA); sample(4'h3); sample(4'hF); idle(1); sample(4'h0); sample(4'h9);
    idle(2);
    chk(expQ.size() == 0, "R3", "all pass-through symbols seen", expQ.size(), 0);
    stop(1'b0, 1'b0);

    // R4/R5: bit-select on index 2
    start(1'b1, 2'd2);
    sample(4'h4); sample(4'h0); sample(4'hC); sample(4'h4);
    chk(symValid == 1'b1, "R4", "strobe after fourth word", symValid, 1);
    idle(1);
    chk(symValid == 1'b0, "R5", "single-cycle strobe", symValid, 0);
    sample(4'h0); sample(4'hB); idle(2);
    chk(symValid == 1'b0, "R5", "no strobe on partial", symValid, 0);
    // R9: inputs change mid-run, latched ones still apply
    bitSelMode = 1'b0; bitIndex = 2'd0;
    sample(4'h4); sample(4'h4);
    idle(1);
    chk(expQ.size() == 0, "R9", "latched config used", expQ.size(), 0);

    // R8: partial pending at disable, words in the tail
    sample(4'hF); sample(4'hF);
    stop(1'b1, 1'b0);
    start(1'b1, 2'd1);
    sample(4'h0); sample(4'h2); sample(4'h0); sample(4'h2);
    idle(1);
    chk(expQ.size() == 0, "R8", "fresh symbol after re-enable", expQ.size(), 0);

    // R7: completing fourth word collides with the disable
    sample(4'h2); sample(4'h2); sample(4'h2);
    stop(1'b1, 1'b0);

    // R11: re-raise during the tail, index 3 boundary captured at restart
    start(1'b1, 2'd0);
    sample(4'h1); sample(4'h0);
    bitSelMode = 1'b1; bitIndex = 2'd3;
    stop(1'b1, 1'b1);
    sample(4'h8); sample(4'h8); sample(4'h0); sample(4'h8);
    idle(1);
    chk(expQ.size() == 0, "R11", "symbol with recaptured index", expQ.size(), 0);
    stop(1'b0, 1'b0);

    // R10: words while stopped do not feed the next symbol
    sample(4'hF); sample(4'hF);
    start(1'b1, 2'd0);
    sample(4'h0); sample(4'h1); sample(4'h1); sample(4'h0);
    idle(2);
    chk(expQ.size() == 0, "R10", "no stale bits", expQ.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule